// File: doc/BRIEF.md
# SPI-Fed Transmit Byte Buffer

This block sits between a serial data source and a transmit byte stream. A host shifts payload bytes in over an SPI mode 0 target port: the data line is taken on every rising edge of the serial clock while the active-low select is held, and each group of eight bits becomes one byte, most significant bit first. The bytes go into a first-in first-out store that holds 4096 entries. The encoder side pulls one byte per request. It does this only while the data-mode input is high.

When the encoder asks for a byte and the store is empty, the block hands out the filler value 0x55 and counts an underrun. A byte that arrives while the store is full is thrown away and counted as an overrun. Both counters are 16 bits wide and stop at their top value. A ready flag tells the host it may send more: the flag stays high until the store holds more than 512 bytes. A synchronous clear input empties the store and zeroes both counters.

The serial inputs are taken as already in the system clock domain. They are oversampled through one register stage, so the serial clock must stay high for at least one system clock and low for at least one system clock.

Top module: `spi_tx_byte_buffer`

## Requirements
- R1: After `rst_n` is low, `fill_count` is 0, `overrun_count` and `underrun_count` are 0, `tx_ready` is 1 and `tx_valid` is 0.
- R2: While `spi_cs_n` is low, `spi_mosi` is taken at each rising edge of `spi_sclk`. Every eight bits form one byte, first bit in the most significant position. Bytes are stored and later delivered in arrival order, and one select-low window may carry any number of bytes.
- R3: When `spi_cs_n` rises in the middle of a byte, the bits already taken are discarded. Nothing is stored, and the next byte starts aligned at its most significant bit.
- R4: `fill_count` equals the number of stored bytes, and it never exceeds 4096.
- R5: `tx_ready` is 1 while `fill_count` is 512 or less, and 0 while `fill_count` is 513 or more.
- R6: A byte that completes while `fill_count` is 4096 is dropped. The stored contents and `fill_count` stay unchanged, and `overrun_count` rises by one.
- R7: When `drain_req` is high with `data_mode` high and the store not empty, the oldest byte appears on `tx_byte` with `tx_valid` high one clock later, and `fill_count` drops by one.
- R8: When `drain_req` is high with `data_mode` high and the store empty, `tx_byte` is 0x55 with `tx_valid` high one clock later, and `underrun_count` rises by one.
- R9: When `data_mode` is low, `drain_req` has no effect: `tx_valid` stays 0 and `fill_count` is unchanged.
- R10: `overrun_count` and `underrun_count` hold at 0xFFFF once they reach it.
- R11: A clock with `clr` high leaves `fill_count`, `overrun_count` and `underrun_count` at 0 and `tx_valid` at 0. It also discards any partly received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of store, counters and serial state |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| data_mode | input | 1 | Enables draining toward the encoder |
| drain_req | input | 1 | Encoder asks for one byte |
| tx_byte | output | 8 | Delivered byte or filler |
| tx_valid | output | 1 | `tx_byte` is valid this clock |
| tx_ready | output | 1 | Host may send more data |
| fill_count | output | 13 | Number of stored bytes |
| overrun_count | output | 16 | Saturating count of dropped bytes |
| underrun_count | output | 16 | Saturating count of filler bytes sent |

## Verification
The hardest states to reach from the ports are the ones at the far ends of the counters and the store. The threshold crossing from 512 to 513 and the full-store drop both need thousands of bytes pushed serially. The stimulus streams them in a few long select-low bursts, so one window carries hundreds of bytes, and it inserts a truncated byte at the 513 mark to show that alignment comes back. Saturating the underrun counter needs 65536 drain requests held back to back on an empty store, with every returned filler checked. A scoreboard model of the store predicts each delivered byte, so ordering after the drop, the partial byte and the threshold points are all confirmed from the output stream.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;

  localparam int unsigned BYTE_W = 8;

  // occupancy after one clock with optional write and read
  function automatic int unsigned occ_next(int unsigned occ, logic wr, logic rd);
    int unsigned n;
    n = occ;
    if (wr) n = n + 1;
    if (rd) n = n - 1;
    return n;
  endfunction

  // counter step that stops at a ceiling
  function automatic int unsigned bump_sat(int unsigned v, logic inc, int unsigned ceil);
    if (inc && v < ceil) return v + 1;
    return v;
  endfunction

  // host may send while occupancy sits at or under the mark
  function automatic logic under_mark(int unsigned occ, int unsigned mark);
    return occ <= mark;
  endfunction

  // ring pointer advance for any depth
  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/txbuf_spi_rx.sv
module txbuf_spi_rx
  import txbuf_pkg::*;
#(
  parameter int unsigned BITS = BYTE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            sclk,
  input  logic            cs_n,
  input  logic            mosi,
  output logic            byte_vld,
  output logic [BITS-1:0] byte_data
);
  localparam int unsigned CW = $clog2(BITS);

  logic            sclk_r, sclk_d, cs_r, mosi_r;
  logic [BITS-2:0] shift_q;
  logic [CW-1:0]   bit_idx;
  logic            rise;

  // one oversampling stage, then edge detect on the sampled clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_r <= 1'b0;
      sclk_d <= 1'b0;
      cs_r   <= 1'b1;
      mosi_r <= 1'b0;
    end else begin
      sclk_r <= sclk;
      sclk_d <= sclk_r;
      cs_r   <= cs_n;
      mosi_r <= mosi;
    end
  end

  assign rise = sclk_r & ~sclk_d & ~cs_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q   <= '0;
      bit_idx   <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else if (clr || cs_r) begin
      bit_idx  <= '0;
      byte_vld <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (rise) begin
        if (bit_idx == CW'(BITS - 1)) begin
          byte_vld  <= 1'b1;
          byte_data <= {shift_q, mosi_r};
          bit_idx   <= '0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
        shift_q <= {shift_q[BITS-3:0], mosi_r};
      end
    end
  end

endmodule

// File: rtl/txbuf_store.sv
module txbuf_store
  import txbuf_pkg::*;
#(
  parameter int unsigned DEPTH  = 4096,
  parameter logic [7:0]  FILLER = 8'h55,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned OW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_vld,
  input  logic [7:0]    wr_data,
  input  logic          rd_req,
  output logic [7:0]    rd_byte,
  output logic          rd_vld,
  output logic [OW-1:0] occupancy,
  output logic          wr_drop,
  output logic          rd_starved
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, do_wr, do_rd;

  assign full       = occupancy == OW'(DEPTH);
  assign empty      = occupancy == '0;
  assign do_wr      = wr_vld & ~full & ~clr;
  assign do_rd      = rd_req & ~empty & ~clr;
  assign wr_drop    = wr_vld & full & ~clr;
  assign rd_starved = rd_req & empty & ~clr;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      occupancy <= '0;
      rd_vld    <= 1'b0;
      rd_byte   <= '0;
    end else if (clr) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      occupancy <= '0;
      rd_vld    <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= AW'(ring_next(int'(wr_ptr), DEPTH));
      if (do_rd) rd_ptr <= AW'(ring_next(int'(rd_ptr), DEPTH));
      occupancy <= OW'(occ_next(int'(occupancy), do_wr, do_rd));
      rd_vld    <= do_rd | rd_starved;
      if (do_rd)           rd_byte <= mem[rd_ptr];
      else if (rd_starved) rd_byte <= FILLER;
    end
  end

endmodule

// File: rtl/txbuf_sat_ctr.sv
module txbuf_sat_ctr
  import txbuf_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] CEIL = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= '0;
    else if (clr) value <= '0;
    else          value <= W'(bump_sat(int'(value), inc, int'(CEIL)));
  end

endmodule

// File: rtl/spi_tx_byte_buffer.sv
module spi_tx_byte_buffer
  import txbuf_pkg::*;
#(
  parameter int unsigned DEPTH     = 4096,
  parameter int unsigned LOW_WATER = 512,
  parameter int unsigned CNT_W     = 16,
  parameter logic [7:0]  FILLER    = 8'h55,
  localparam int unsigned OW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  input  logic             data_mode,
  input  logic             drain_req,
  output logic [7:0]       tx_byte,
  output logic             tx_valid,
  output logic             tx_ready,
  output logic [OW-1:0]    fill_count,
  output logic [CNT_W-1:0] overrun_count,
  output logic [CNT_W-1:0] underrun_count
);
  localparam int unsigned NCTR = 2;

  // named internal events, also seen by the bound checker
  logic                       rx_vld;
  logic [7:0]                 rx_byte;
  logic                       pull;
  logic                       wr_drop;
  logic                       rd_starved;
  logic [NCTR-1:0]            ctr_evt;
  logic [NCTR-1:0][CNT_W-1:0] ctr_val;

  txbuf_spi_rx #(.BITS(BYTE_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .byte_vld  (rx_vld),
    .byte_data (rx_byte)
  );

  assign pull = drain_req & data_mode;

  txbuf_store #(.DEPTH(DEPTH), .FILLER(FILLER)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .wr_vld     (rx_vld),
    .wr_data    (rx_byte),
    .rd_req     (pull),
    .rd_byte    (tx_byte),
    .rd_vld     (tx_valid),
    .occupancy  (fill_count),
    .wr_drop    (wr_drop),
    .rd_starved (rd_starved)
  );

  assign ctr_evt = {rd_starved, wr_drop};

  for (genvar g = 0; g < NCTR; g++) begin : g_ctr
    txbuf_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (ctr_evt[g]),
      .value (ctr_val[g])
    );
  end

  assign overrun_count  = ctr_val[0];
  assign underrun_count = ctr_val[1];
  assign tx_ready       = under_mark(int'(fill_count), LOW_WATER);

endmodule

// File: rtl/txbuf_checks.sv
module txbuf_checks #(
  parameter int unsigned DEPTH     = 4096,
  parameter int unsigned LOW_WATER = 512,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned OW        = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             data_mode,
  input logic             drain_req,
  input logic [7:0]       tx_byte,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [OW-1:0]    fill_count,
  input logic [CNT_W-1:0] overrun_count,
  input logic [CNT_W-1:0] underrun_count,
  input logic             wr_drop,
  input logic             rd_starved
);
  localparam logic [CNT_W-1:0] TOP = '1;

  a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= OW'(DEPTH));

  a_r5_ready_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> fill_count == OW'(LOW_WATER + 1));

  a_r6_overrun_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_drop && overrun_count != TOP) |=> overrun_count == $past(overrun_count) + 1'b1);

  a_r6_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_drop && !(drain_req && data_mode)) |=> fill_count == OW'(DEPTH));

  a_r8_filler: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_req && data_mode && fill_count == '0 && !clr) |=> (tx_valid && tx_byte == 8'h55));

  a_r8_underrun_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_starved && underrun_count != TOP) |=> underrun_count == $past(underrun_count) + 1'b1);

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!(drain_req && data_mode)) |=> !tx_valid);

  a_r10_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_count == TOP && overrun_count == TOP && !clr) |=>
      (underrun_count == TOP && overrun_count == TOP));

  a_r10_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_count == TOP && !clr) |=> underrun_count == TOP);

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fill_count == '0 && overrun_count == '0 && underrun_count == '0 && !tx_valid));

endmodule

bind spi_tx_byte_buffer txbuf_checks #(
  .DEPTH(DEPTH), .LOW_WATER(LOW_WATER), .CNT_W(CNT_W), .OW(OW)
) u_checks (
  .clk            (clk),
  .rst_n          (rst_n),
  .clr            (clr),
  .data_mode      (data_mode),
  .drain_req      (drain_req),
  .tx_byte        (tx_byte),
  .tx_valid       (tx_valid),
  .tx_ready       (tx_ready),
  .fill_count     (fill_count),
  .overrun_count  (overrun_count),
  .underrun_count (underrun_count),
  .wr_drop        (wr_drop),
  .rd_starved     (rd_starved)
);

// File: tb/spi_tx_byte_buffer_test.sv
module spi_tx_byte_buffer_test;
  localparam int unsigned DEPTH = 4096;

  logic        clk = 1'b0;
  logic        rst_n, clr, sclk, cs_n, mosi, data_mode, drain_req;
  logic [7:0]  tx_byte;
  logic        tx_valid, tx_ready;
  logic [12:0] fill_count;
  logic [15:0] overrun_count, underrun_count;

  int checks = 0;
  int errors = 0;
  logic [7:0] model_q[$];
  logic [7:0] exp_q[$];
  string      exp_tag[$];
  int         m_over = 0;
  int         m_under = 0;

  always #10 clk = ~clk;

  spi_tx_byte_buffer uut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .data_mode(data_mode), .drain_req(drain_req),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .fill_count(fill_count), .overrun_count(overrun_count),
    .underrun_count(underrun_count)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int k);
    return 8'((k * 37 + 11) & 8'hFF);
  endfunction

  // monitor: compares each delivered byte against the scoreboard
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected tx_valid actual=%0h expected=none", tx_byte);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = exp_tag.pop_front();
        if (tx_byte !== e) begin
          errors++;
          $display("FAIL %s delivered byte actual=%0h expected=%0h", t, tx_byte, e);
        end
      end
    end
  end

  task automatic spi_bit(logic b);
    @(negedge clk); mosi = b; sclk = 1'b0;
    @(negedge clk); sclk = 1'b1;
  endtask

  // R2: many bytes inside one select-low window, MSB first
  task automatic spi_burst(int n, int base);
    @(negedge clk); cs_n = 1'b0;
    for (int k = 0; k < n; k++) begin
      automatic logic [7:0] b = pat(base + k);
      for (int i = 7; i >= 0; i--) spi_bit(b[i]);
      if (model_q.size() < DEPTH) model_q.push_back(b);
      else if (m_over < 65535) m_over++;
    end
    @(negedge clk); sclk = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic drain(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); drain_req = 1'b1;
      if (data_mode) begin
        if (model_q.size() > 0) begin
          exp_q.push_back(model_q.pop_front());
          exp_tag.push_back("R7");
        end else begin
          exp_q.push_back(8'h55);
          exp_tag.push_back("R8");
          if (m_under < 65535) m_under++;
        end
      end
    end
    @(negedge clk); drain_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog actual=hung expected=completed");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    data_mode = 1'b0; drain_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fill", int'(fill_count), 0);
    chk("R1 overrun", int'(overrun_count), 0);
    chk("R1 underrun", int'(underrun_count), 0);
    chk("R1 ready", int'(tx_ready), 1);
    chk("R1 valid", int'(tx_valid), 0);

    // R2/R4/R5 fill up to the threshold
    spi_burst(512, 0);
    chk("R4 fill at 512", int'(fill_count), 512);
    chk("R5 ready at 512", int'(tx_ready), 1);
    spi_burst(1, 512);
    chk("R4 fill at 513", int'(fill_count), 513);
    chk("R5 ready at 513", int'(tx_ready), 0);

    // R3 truncated byte leaves nothing behind
    @(negedge clk); cs_n = 1'b0;
    for (int i = 0; i < 5; i++) spi_bit(1'b1);
    @(negedge clk); sclk = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 fill after partial", int'(fill_count), 513);

    // R6 fill to the top, three more are dropped
    spi_burst(3583 + 3, 513);
    chk("R4 fill full", int'(fill_count), 4096);
    chk("R6 overrun", int'(overrun_count), m_over);
    chk("R6 overrun three", m_over, 3);
    chk("R5 ready full", int'(tx_ready), 0);

    // R9 requests outside data mode are ignored
    drain(5);
    chk("R9 fill unchanged", int'(fill_count), 4096);

    // R7 drain in order, crossing the threshold downward
    data_mode = 1'b1;
    drain(3583);
    chk("R5 fill 513", int'(fill_count), 513);
    chk("R5 ready low at 513", int'(tx_ready), 0);
    drain(1);
    chk("R5 ready high at 512", int'(tx_ready), 1);
    drain(512);
    chk("R7 empty", int'(fill_count), 0);
    chk("R8 no underrun yet", int'(underrun_count), 0);
    drain(2);
    chk("R8 underrun two", int'(underrun_count), 2);

    // R11 clear
    data_mode = 1'b0;
    spi_burst(4, 900);
    chk("R4 fill four", int'(fill_count), 4);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    model_q.delete(); m_over = 0; m_under = 0;
    chk("R11 fill", int'(fill_count), 0);
    chk("R11 overrun", int'(overrun_count), 0);
    chk("R11 underrun", int'(underrun_count), 0);
    chk("R11 ready", int'(tx_ready), 1);
    data_mode = 1'b1;
    drain(1);
    chk("R11 filler after clear", int'(underrun_count), 1);

    // R10 saturation of the underrun counter
    drain(65536);
    chk("R10 underrun held", int'(underrun_count), 16'hFFFF);
    chk("R10 model", m_under, 65535);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R11 underrun cleared", int'(underrun_count), 0);

    repeat (4) @(negedge clk);
    chk("R7 all expected delivered", exp_q.size(), 0);
    finish_run();
  end

endmodule